// File: doc/BRIEF.md
# UART Control/Status Register Front End

This block is the software-visible face of a serial port. A processor reaches it over a simple 32-bit bus with one access per cycle. Each access carries an enable, a write flag, a byte address and write data. Read data comes back in the same cycle. Behind the register map are two byte FIFOs of 32 entries each. The transmit FIFO is filled by writes to the transmit data register and drained by an external serializer. The receive FIFO is filled by an external deserializer and drained by reads of the receive data register.

The block does not build the serial waveform and does not generate the bit clock. The line-format word, the baud word and the oversampling word are held in registers and driven out unchanged to a separate divider and shifter chain. A status register combines the FIFO levels with the serializer's busy signal into three flags. Software uses these flags to poll before it pushes or pops a byte.

Top module: `uart_csr_top`

## Requirements
- R1: The register map decodes the full byte address as follows: 0x00 receive data, 0x04 transmit data, 0x08 line control, 0x0C status, 0x10 baud word, 0x14 oversampling word. The baud and oversampling registers read back all 32 written bits and drive `baud_cfg` and `ovs_cfg` from the cycle after the write.
- R2: A write to 0x04 pushes `bus_wdata[7:0]` into the transmit FIFO. Bytes appear on `tx_data` in the order they were written, with `tx_valid` high while the FIFO holds any byte. Each cycle with `tx_take` high removes the head byte.
- R3: Status bit 11 is 1 when the transmit FIFO holds 32 bytes. A write to 0x04 in that state is discarded, and the bytes already queued are unchanged.
- R4: Status bit 4 is 1 when the receive FIFO holds at least one byte. A read of 0x00 then returns the oldest byte in bits 7:0, with bits 31:8 at zero, and removes that byte.
- R5: A read of 0x00 while the receive FIFO is empty returns 0 and removes nothing.
- R6: Status bit 6 is 1 only while the transmit FIFO is empty and `tx_busy` is low.
- R7: A write to 0x08 with bit 14 set empties the receive FIFO. A write with bit 15 set empties the transmit FIFO. Either takes effect at that clock edge and wins over a simultaneous push or take. Bits 14 and 15 always read back as 0. The other written bits are kept and driven on `line_cfg`.
- R8: Reads of any other address return 0. Writes to any other address, to 0x00 or to 0x0C change no register and no FIFO.
- R9: After a synchronous reset, both FIFOs are empty and the line control, baud and oversampling registers are 0. A line control of 0 means no parity and one stop bit.
- R10: When the receive FIFO holds 32 bytes, `rx_push` is ignored and the bytes already queued are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tx_data | output | 8 | Head byte of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Serializer removes the head byte |
| tx_busy | input | 1 | Serializer is shifting a byte |
| rx_byte | input | 8 | Byte from the deserializer |
| rx_push | input | 1 | Write `rx_byte` into the receive FIFO |
| line_cfg | output | 32 | Line control word, flush bits cleared |
| baud_cfg | output | 32 | Baud divider word |
| ovs_cfg | output | 32 | Oversampling word |

## Verification
The hardest states to reach are the two FIFO boundaries. Reaching them takes 32 accepted pushes and then a 33rd push that must leave no trace. The only way to see that trace is to drain all 32 entries and compare each one in order. The bench fills each FIFO past capacity, with bus writes on the transmit side and `rx_push` pulses on the receive side. It then drains every entry and checks that the last byte out is the 32nd, and that the next pop finds the FIFO empty. Flush is checked on FIFOs that hold data, and the idle flag is checked with `tx_busy` high while the FIFO is empty.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int CSR_AW     = 8;
    localparam int DATA_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int FIFO_DEPTH = 32;

    localparam logic [CSR_AW-1:0] OFS_RXD  = 8'h00;
    localparam logic [CSR_AW-1:0] OFS_TXD  = 8'h04;
    localparam logic [CSR_AW-1:0] OFS_CTRL = 8'h08;
    localparam logic [CSR_AW-1:0] OFS_STAT = 8'h0C;
    localparam logic [CSR_AW-1:0] OFS_BAUD = 8'h10;
    localparam logic [CSR_AW-1:0] OFS_OVS  = 8'h14;

    localparam int ST_RX_RDY   = 4;
    localparam int ST_TX_IDLE  = 6;
    localparam int ST_TX_FULL  = 11;
    localparam int CT_RX_FLUSH = 14;
    localparam int CT_TX_FLUSH = 15;

    typedef enum logic [2:0] {
        SEL_RXD,
        SEL_TXD,
        SEL_CTRL,
        SEL_STAT,
        SEL_BAUD,
        SEL_OVS,
        SEL_NONE
    } csr_sel_e;

    typedef struct packed {
        logic rx_rdy;
        logic tx_idle;
        logic tx_full;
    } csr_stat_t;

    function automatic csr_sel_e csr_decode(input logic [CSR_AW-1:0] a);
        csr_sel_e s;
        case (a)
            OFS_RXD:  s = SEL_RXD;
            OFS_TXD:  s = SEL_TXD;
            OFS_CTRL: s = SEL_CTRL;
            OFS_STAT: s = SEL_STAT;
            OFS_BAUD: s = SEL_BAUD;
            OFS_OVS:  s = SEL_OVS;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input csr_stat_t st);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[ST_RX_RDY]  = st.rx_rdy;
        w[ST_TX_IDLE] = st.tx_idle;
        w[ST_TX_FULL] = st.tx_full;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] flush_mask();
        logic [DATA_W-1:0] m;
        m              = '0;
        m[CT_RX_FLUSH] = 1'b1;
        m[CT_TX_FLUSH] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/uart_csr_fifo.sv
module uart_csr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;
    logic         push_ok;
    logic         pop_ok;

    always_comb begin
        empty   = (wp == rp);
        full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = mem[rp[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp[AW-1:0]] <= din;
    end

endmodule

// File: rtl/uart_csr_regs.sv
module uart_csr_regs
    import uart_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [CSR_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  csr_stat_t         stat,
    input  logic [BYTE_W-1:0] rx_head,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic [DATA_W-1:0] line_cfg,
    output logic [DATA_W-1:0] baud_cfg,
    output logic [DATA_W-1:0] ovs_cfg
);
    csr_sel_e          sel;
    logic              wr;
    logic              rd;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] baud_q;
    logic [DATA_W-1:0] ovs_q;

    always_comb begin
        sel      = csr_decode(bus_addr);
        wr       = bus_en && bus_we;
        rd       = bus_en && !bus_we;
        tx_push  = wr && (sel == SEL_TXD);
        tx_byte  = bus_wdata[BYTE_W-1:0];
        rx_pop   = rd && (sel == SEL_RXD) && stat.rx_rdy;
        rx_flush = wr && (sel == SEL_CTRL) && bus_wdata[CT_RX_FLUSH];
        tx_flush = wr && (sel == SEL_CTRL) && bus_wdata[CT_TX_FLUSH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            baud_q <= '0;
            ovs_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL: ctrl_q <= bus_wdata & ~flush_mask();
                SEL_BAUD: baud_q <= bus_wdata;
                SEL_OVS:  ovs_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (sel)
                SEL_RXD:  if (stat.rx_rdy) bus_rdata[BYTE_W-1:0] = rx_head;
                SEL_CTRL: bus_rdata = ctrl_q;
                SEL_STAT: bus_rdata = stat_word(stat);
                SEL_BAUD: bus_rdata = baud_q;
                SEL_OVS:  bus_rdata = ovs_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign line_cfg = ctrl_q;
    assign baud_cfg = baud_q;
    assign ovs_cfg  = ovs_q;

endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
    import uart_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [CSR_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              tx_busy,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_push,
    output logic [DATA_W-1:0] line_cfg,
    output logic [DATA_W-1:0] baud_cfg,
    output logic [DATA_W-1:0] ovs_cfg
);
    logic              tx_push;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_flush;
    logic              tx_empty;
    logic              tx_full;
    logic              rx_pop;
    logic              rx_flush;
    logic              rx_empty;
    logic              rx_full;
    logic [BYTE_W-1:0] rx_head;
    csr_stat_t         stat;

    always_comb begin
        stat.rx_rdy  = !rx_empty;
        stat.tx_idle = tx_empty && !tx_busy;
        stat.tx_full = tx_full;
        tx_valid     = !tx_empty;
    end

    uart_csr_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat      (stat),
        .rx_head   (rx_head),
        .tx_push   (tx_push),
        .tx_byte   (tx_byte),
        .rx_pop    (rx_pop),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .line_cfg  (line_cfg),
        .baud_cfg  (baud_cfg),
        .ovs_cfg   (ovs_cfg)
    );

    uart_csr_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .push  (tx_push),
        .din   (tx_byte),
        .pop   (tx_take),
        .dout  (tx_data),
        .empty (tx_empty),
        .full  (tx_full)
    );

    uart_csr_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
    import uart_csr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [CSR_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_take,
    input logic              tx_busy,
    input logic [DATA_W-1:0] baud_cfg,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              rx_full
);
    logic rd_any;
    logic wr_ctl;
    assign rd_any = bus_en && !bus_we;
    assign wr_ctl = bus_en && bus_we && (bus_addr == OFS_CTRL);

    p_baud_cfg_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == OFS_BAUD) |=> (baud_cfg == $past(bus_wdata)));

    p_tx_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !tx_take && !(wr_ctl && bus_wdata[CT_TX_FLUSH])) |=> tx_full);

    p_rx_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !(rd_any && bus_addr == OFS_RXD) && !(wr_ctl && bus_wdata[CT_RX_FLUSH])) |=> rx_full);

    p_rx_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_any && bus_addr == OFS_RXD) |-> (bus_rdata[DATA_W-1:BYTE_W] == '0));

    p_rx_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_any && bus_addr == OFS_RXD && rx_empty) |-> (bus_rdata == '0));

    p_tx_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_any && bus_addr == OFS_STAT) |-> (bus_rdata[ST_TX_IDLE] == (tx_empty && !tx_busy)));

    p_tx_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && bus_wdata[CT_TX_FLUSH]) |=> tx_empty);

    p_rx_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && bus_wdata[CT_RX_FLUSH]) |=> rx_empty);

    p_ctrl_rd_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_any && bus_addr == OFS_CTRL) |-> (bus_rdata[CT_TX_FLUSH:CT_RX_FLUSH] == 2'b00));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_any && csr_decode(bus_addr) == SEL_NONE) |-> (bus_rdata == '0));

endmodule

bind uart_csr_top uart_csr_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_take   (tx_take),
    .tx_busy   (tx_busy),
    .baud_cfg  (baud_cfg),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full),
    .rx_empty  (rx_empty),
    .rx_full   (rx_full)
);

// File: tb/test_uart_csr_top.sv
`timescale 1ns/1ps
module test_uart_csr_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_take = 1'b0;
    logic        tx_busy = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_push = 1'b0;
    logic [31:0] line_cfg;
    logic [31:0] baud_cfg;
    logic [31:0] ovs_cfg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_csr_top i_uart_csr_top (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_take   (tx_take),
        .tx_busy   (tx_busy),
        .rx_byte   (rx_byte),
        .rx_push   (rx_push),
        .line_cfg  (line_cfg),
        .baud_cfg  (baud_cfg),
        .ovs_cfg   (ovs_cfg)
    );

    // entry: {req[3:0], we, addr[7:0], data[31:0], expected[31:0]}
    localparam int NV = 16;
    localparam logic [76:0] VEC [NV] = '{
        {4'd1,  1'b1, 8'h10, 32'h000A_0123, 32'h0},           // R1 baud write
        {4'd1,  1'b0, 8'h10, 32'h0,         32'h000A_0123},   // R1 baud readback
        {4'd1,  1'b1, 8'h14, 32'h3F3F_3F3F, 32'h0},           // R1 ovs write
        {4'd1,  1'b0, 8'h14, 32'h0,         32'h3F3F_3F3F},   // R1 ovs readback
        {4'd7,  1'b1, 8'h08, 32'h0000_C0A5, 32'h0},           // R7 ctrl with both flush bits
        {4'd7,  1'b0, 8'h08, 32'h0,         32'h0000_00A5},   // R7 flush bits read 0
        {4'd6,  1'b0, 8'h0C, 32'h0,         32'h0000_0040},   // R6 idle
        {4'd2,  1'b1, 8'h04, 32'h1234_5678, 32'h0},           // R2 push
        {4'd6,  1'b0, 8'h0C, 32'h0,         32'h0000_0000},   // R6 not idle
        {4'd7,  1'b1, 8'h08, 32'h0000_8000, 32'h0},           // R7 tx flush
        {4'd7,  1'b0, 8'h0C, 32'h0,         32'h0000_0040},   // R7 tx empty again
        {4'd8,  1'b0, 8'h18, 32'h0,         32'h0},           // R8 unmapped read
        {4'd8,  1'b1, 8'h1C, 32'hFFFF_FFFF, 32'h0},           // R8 unmapped write
        {4'd8,  1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},           // R8 status write ignored
        {4'd5,  1'b0, 8'h00, 32'h0,         32'h0},           // R5 empty rx read
        {4'd8,  1'b0, 8'h0C, 32'h0,         32'h0000_0040}    // R8 nothing changed
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_out(output logic v, output logic [7:0] b);
        @(negedge clk);
        v = tx_valid; b = tx_data;
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        v;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(8'h0C, r); check("R9 status", r, 32'h40);
        rd(8'h08, r); check("R9 ctrl", r, 32'h0);
        check("R9 line_cfg", line_cfg, 32'h0);
        check("R9 baud_cfg", baud_cfg, 32'h0);
        check("R9 ovs_cfg", ovs_cfg, 32'h0);
        check("R9 tx_valid", {31'b0, tx_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][71:64], r);
                check($sformatf("R%0d vector %0d", VEC[i][76:73], i), r, VEC[i][31:0]);
            end
        end
        check("R1 baud_cfg port", baud_cfg, 32'h000A_0123);
        check("R1 ovs_cfg port", ovs_cfg, 32'h3F3F_3F3F);
        check("R7 line_cfg port", line_cfg, 32'h0);

        // R2 order of transmit bytes
        wr(8'h04, 32'hFFFF_FF11);
        wr(8'h04, 32'h0000_0022);
        wr(8'h04, 32'h0000_0033);
        tx_out(v, b); check("R2 byte0", {23'b0, v, b}, {23'b0, 1'b1, 8'h11});
        tx_out(v, b); check("R2 byte1", {23'b0, v, b}, {23'b0, 1'b1, 8'h22});
        tx_out(v, b); check("R2 byte2", {23'b0, v, b}, {23'b0, 1'b1, 8'h33});
        @(negedge clk); check("R2 drained", {31'b0, tx_valid}, 32'h0);

        // R6 busy serializer with empty FIFO
        tx_busy = 1'b1;
        rd(8'h0C, r); check("R6 busy", r, 32'h0);
        tx_busy = 1'b0;

        // R3 transmit overflow
        for (int i = 0; i < 33; i++) wr(8'h04, 32'h80 + i);
        rd(8'h0C, r); check("R3 full flag", r, 32'h800);
        for (int i = 0; i < 32; i++) begin
            tx_out(v, b);
            check($sformatf("R3 drain %0d", i), {23'b0, v, b}, {23'b0, 1'b1, 8'h80 + i[7:0]});
        end
        @(negedge clk); check("R3 33rd dropped", {31'b0, tx_valid}, 32'h0);

        // R4 receive path
        rx_in(8'hA1);
        rx_in(8'hB2);
        rd(8'h0C, r); check("R4 rx ready", r, 32'h50);
        rd(8'h00, r); check("R4 first", r, 32'hA1);
        rd(8'h00, r); check("R4 second", r, 32'hB2);
        rd(8'h0C, r); check("R4 drained", r, 32'h40);

        // R5 empty read pops nothing
        rd(8'h00, r); check("R5 empty", r, 32'h0);
        rx_in(8'hC3);
        rd(8'h00, r); check("R5 after empty", r, 32'hC3);
        rd(8'h00, r); check("R5 empty again", r, 32'h0);

        // R10 receive overflow
        for (int i = 0; i < 33; i++) rx_in(8'h10 + i[7:0]);
        for (int i = 0; i < 32; i++) begin
            rd(8'h00, r);
            check($sformatf("R10 drain %0d", i), r, 32'h10 + i);
        end
        rd(8'h00, r); check("R10 33rd dropped", r, 32'h0);

        // R7 receive flush with data queued
        rx_in(8'h01); rx_in(8'h02); rx_in(8'h03);
        wr(8'h08, 32'h0000_4000);
        rd(8'h0C, r); check("R7 rx flush status", r, 32'h40);
        rd(8'h00, r); check("R7 rx flush read", r, 32'h0);
        rx_in(8'h5A);
        rd(8'h00, r); check("R7 rx after flush", r, 32'h5A);

        // R7 transmit flush with data queued, then fresh push
        wr(8'h04, 32'h66); wr(8'h04, 32'h77);
        wr(8'h08, 32'h0000_8003);
        @(negedge clk); check("R7 tx flush", {31'b0, tx_valid}, 32'h0);
        check("R7 line kept", line_cfg, 32'h3);
        wr(8'h04, 32'h99);
        tx_out(v, b); check("R7 tx after flush", {23'b0, v, b}, {23'b0, 1'b1, 8'h99});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule